// File: doc/BRIEF.md
# Serial Peripheral Master with Divided Bit Clock

This block moves one word per transfer over a four-wire synchronous serial link, acting as the clocking side. A one-cycle `start` strobe loads the transmit word. The block then pulls the active-low slave-enable line low and generates a serial clock that idles low. It shifts the word out most significant bit first and samples the return line on every rising clock edge. When the word is complete it releases the enable and presents the received word together with a one-cycle `done` pulse.

All logic runs on the system clock. A sample-rate tick is taken from one of two sources, chosen per transfer: every second system clock, or each rising edge of an external clock after synchronization. The bit clock period is `1 + div_val` ticks. The high phase is one tick longer than the low phase when the divide value is even, and the two phases are equal when it is odd. The data output comes with a separate output-enable so that a pad can float the line outside the data window.

Top module: `ser_master`

## Requirements
- R1: Out of reset and whenever no transfer is in progress, `sclk` is 0, `sen_n` is 1, `sdo_oe` is 0, `busy` is 0 and `done` is 0.
- R2: With divide value D (a value of 0 is handled as 1), the high phase of `sclk` lasts D/2+1 ticks and the low phase D/2 ticks when D is even; both phases last (D+1)/2 ticks when D is odd.
- R3: With `src_ext` = 0 one tick occurs every 2 system clocks; with `src_ext` = 1 one tick occurs per rising edge of `ext_clk`. The source and divide value are captured when `start` is accepted.
- R4: `sen_n` falls exactly one bit period (high plus low ticks) before the first rising edge of `sclk`.
- R5: `sdo_oe` rises one low-phase width after `sen_n` falls, with the MSB of `tx_word` on `sdo`. Each later bit appears at a rising `sclk` edge, and `sdo` is stable while `sclk` is low. `sdo_oe` is only 1 while `sen_n` is 0.
- R6: `sdi` is sampled at each rising `sclk` edge, the first sample becoming the MSB. The assembled word is on `rx_word` when `done` pulses.
- R7: `sdo_oe` falls at the last rising `sclk` edge. `sen_n` stays low one high-phase width after that edge and rises in the same cycle that `sclk` falls.
- R8: `busy` is 1 from the cycle after `start` is accepted until the release. `done` is a single-cycle pulse in the cycle `sen_n` rises.
- R9: A `start` while `busy` is 1 is ignored: the word in flight is unchanged and no second transfer follows.
- R10: Each transfer has exactly WORD_W rising edges of `sclk`, and `sclk` is 1 only while `sen_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| tx_word | input | WORD_W | Word to send, MSB first |
| div_val | input | DIV_W | Bit clock divide value |
| src_ext | input | 1 | Tick source: 0 system clock / 2, 1 external clock |
| ext_clk | input | 1 | External sample-rate clock |
| sdi | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial bit clock, idle low |
| sen_n | output | 1 | Active-low slave enable |
| sdo | output | 1 | Serial data to the slave |
| sdo_oe | output | 1 | Drive enable for sdo (0 = float) |
| rx_word | output | WORD_W | Last received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The enable falls on the first tick after `start`. From that point every edge of `sclk`, `sdo_oe` and `sen_n` lands a whole number of ticks later: 2 system clocks per tick on the internal source, and 6 per tick with the bench's external clock. `done` and `rx_word` are due in the same cycle as the rising `sen_n`, and `busy` is due one cycle after `start`. The bench records the cycle of each observed edge on the falling system clock and compares the differences against tick counts it derives from the divide value, so the variable latency from `start` to the first tick never enters an expected value.

// File: rtl/ser_master_pkg.sv
package ser_master_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ARM,
      PH_LEAD_LO,
      PH_LEAD_HI,
      PH_HIGH,
      PH_LOW
   } ph_state_t;

   // Divide value 0 cannot be split into whole ticks; it runs as 1.
   function automatic int eff_div(input int d);
      return (d == 0) ? 1 : d;
   endfunction

   function automatic int high_ticks(input int d);
      int e;
      e = eff_div(d);
      return (e % 2 == 0) ? (e / 2 + 1) : ((e + 1) / 2);
   endfunction

   function automatic int low_ticks(input int d);
      int e;
      e = eff_div(d);
      return (e % 2 == 0) ? (e / 2) : ((e + 1) / 2);
   endfunction

endpackage

// File: rtl/ser_tick_gen.sv
module ser_tick_gen #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_ext,
   input  logic ext_clk,
   output logic tick
);

   localparam int LAST = SYNC_STAGES - 1;

   logic             half_q;
   logic [LAST:0]    sync_q;
   logic             ext_prev_q;
   logic             ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= 1'b0;
      else        half_q <= ~half_q;
   end

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= ext_clk;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev_q <= 1'b0;
      else        ext_prev_q <= sync_q[LAST];
   end

   assign ext_rise = sync_q[LAST] & ~ext_prev_q;
   assign tick     = src_ext ? ext_rise : half_q;

endmodule

// File: rtl/ser_phase_ctl.sv
module ser_phase_ctl
   import ser_master_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic [DIV_W-1:0] div_val,
   output logic             sclk,
   output logic             sen_n,
   output logic             oe,
   output logic             busy,
   output logic             done,
   output logic             load_ev,
   output logic             rise_ev,
   output logic             last_ev,
   output logic             end_ev
);

   localparam int CNT_W = DIV_W + 1;
   localparam int BIT_W = $clog2(WORD_W + 1);
   localparam logic [BIT_W-1:0] FULL_CNT = BIT_W'(WORD_W);
   localparam logic [BIT_W-1:0] PRE_CNT  = BIT_W'(WORD_W - 1);

   ph_state_t         state_q;
   logic [CNT_W-1:0]  hi_len_q, lo_len_q, cnt_q, cur_len;
   logic [BIT_W-1:0]  bits_q;
   logic              ph_end;
   logic              in_phase;

   always_comb begin
      unique case (state_q)
         PH_LEAD_LO, PH_LOW: cur_len = lo_len_q;
         default:            cur_len = hi_len_q;
      endcase
   end

   assign in_phase = (state_q != PH_IDLE) && (state_q != PH_ARM);
   assign ph_end   = in_phase && tick && (cnt_q == cur_len - CNT_W'(1));
   assign load_ev  = start && (state_q == PH_IDLE);
   assign rise_ev  = ph_end && ((state_q == PH_LEAD_HI) || (state_q == PH_LOW));
   assign last_ev  = rise_ev && (bits_q == PRE_CNT);
   assign end_ev   = ph_end && (state_q == PH_HIGH) && (bits_q == FULL_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PH_IDLE;
         hi_len_q <= '0;
         lo_len_q <= '0;
         cnt_q    <= '0;
         bits_q   <= '0;
         sclk     <= 1'b0;
         sen_n    <= 1'b1;
         oe       <= 1'b0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (in_phase && tick) begin
            cnt_q <= ph_end ? '0 : cnt_q + CNT_W'(1);
         end
         unique case (state_q)
            PH_IDLE: begin
               if (start) begin
                  state_q  <= PH_ARM;
                  hi_len_q <= CNT_W'(high_ticks(int'(div_val)));
                  lo_len_q <= CNT_W'(low_ticks(int'(div_val)));
                  busy     <= 1'b1;
               end
            end
            PH_ARM: begin
               if (tick) begin
                  state_q <= PH_LEAD_LO;
                  sen_n   <= 1'b0;
                  cnt_q   <= '0;
                  bits_q  <= '0;
               end
            end
            PH_LEAD_LO: begin
               if (ph_end) begin
                  state_q <= PH_LEAD_HI;
                  oe      <= 1'b1;
               end
            end
            PH_LEAD_HI: begin
               if (ph_end) begin
                  state_q <= PH_HIGH;
                  sclk    <= 1'b1;
                  bits_q  <= BIT_W'(1);
               end
            end
            PH_HIGH: begin
               if (ph_end) begin
                  sclk <= 1'b0;
                  if (bits_q == FULL_CNT) begin
                     state_q <= PH_IDLE;
                     sen_n   <= 1'b1;
                     busy    <= 1'b0;
                     done    <= 1'b1;
                  end else begin
                     state_q <= PH_LOW;
                  end
               end
            end
            PH_LOW: begin
               if (ph_end) begin
                  state_q <= PH_HIGH;
                  sclk    <= 1'b1;
                  bits_q  <= bits_q + BIT_W'(1);
                  if (bits_q == PRE_CNT) oe <= 1'b0;
               end
            end
            default: state_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_ev,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              rise_ev,
   input  logic              last_ev,
   input  logic              end_ev,
   input  logic              sdi,
   input  logic              oe,
   output logic              sdo,
   output logic [WORD_W-1:0] rx_word
);

   localparam int MSB = WORD_W - 1;

   logic [MSB:0] tx_sr_q;
   logic [MSB:0] rx_sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr_q <= '0;
         rx_sr_q <= '0;
         rx_word <= '0;
      end else begin
         if (load_ev) begin
            tx_sr_q <= tx_word;
         end else if (rise_ev && !last_ev) begin
            tx_sr_q <= {tx_sr_q[MSB-1:0], 1'b0};
         end
         if (rise_ev) begin
            rx_sr_q <= {rx_sr_q[MSB-1:0], sdi};
         end
         if (end_ev) begin
            rx_word <= rx_sr_q;
         end
      end
   end

   assign sdo = oe & tx_sr_q[MSB];

endmodule

// File: rtl/ser_master.sv
module ser_master #(
   parameter int WORD_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              src_ext,
   input  logic              ext_clk,
   input  logic              sdi,
   output logic              sclk,
   output logic              sen_n,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [WORD_W-1:0] rx_word,
   output logic              busy,
   output logic              done
);

   initial begin
      if (WORD_W < 2)      $fatal(1, "ser_master: WORD_W must be at least 2");
      if (DIV_W < 1)       $fatal(1, "ser_master: DIV_W must be at least 1");
      if (DIV_W > 16)      $fatal(1, "ser_master: DIV_W must not exceed 16");
      if (SYNC_STAGES < 2) $fatal(1, "ser_master: SYNC_STAGES must be at least 2");
   end

   logic src_q;
   logic tick;
   logic load_ev, rise_ev, last_ev, end_ev;

   ser_phase_ctl #(
      .WORD_W (WORD_W),
      .DIV_W  (DIV_W)
   ) i_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tick    (tick),
      .div_val (div_val),
      .sclk    (sclk),
      .sen_n   (sen_n),
      .oe      (sdo_oe),
      .busy    (busy),
      .done    (done),
      .load_ev (load_ev),
      .rise_ev (rise_ev),
      .last_ev (last_ev),
      .end_ev  (end_ev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       src_q <= 1'b0;
      else if (load_ev) src_q <= src_ext;
   end

   ser_tick_gen #(
      .SYNC_STAGES (SYNC_STAGES)
   ) i_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_ext (src_q),
      .ext_clk (ext_clk),
      .tick    (tick)
   );

   ser_shifter #(
      .WORD_W (WORD_W)
   ) i_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_ev (load_ev),
      .tx_word (tx_word),
      .rise_ev (rise_ev),
      .last_ev (last_ev),
      .end_ev  (end_ev),
      .sdi     (sdi),
      .oe      (sdo_oe),
      .sdo     (sdo),
      .rx_word (rx_word)
   );

endmodule

// File: rtl/ser_master_chk.sv
module ser_master_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic sclk,
   input logic sen_n,
   input logic sdo,
   input logic sdo_oe
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sen_n && !sclk && !sdo_oe));

   p_clk_inside_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !sen_n);

   p_oe_inside_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !sen_n);

   p_data_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && $past(sdo_oe) && !sclk) |-> $stable(sdo));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sen_n && $past(!sen_n)));

   p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_clk_falls_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sen_n) |-> $fell(sclk));

endmodule

bind ser_master ser_master_chk i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .sclk   (sclk),
   .sen_n  (sen_n),
   .sdo    (sdo),
   .sdo_oe (sdo_oe)
);

// File: tb/test_ser_master.sv
module test_ser_master;

   localparam int CLK_PERIOD = 10;
   localparam int EXT_HALF   = 30;
   localparam int W          = 8;
   localparam int DW         = 8;
   localparam int TC_INT     = 2;
   localparam int TC_EXT     = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  tx_word = '0;
   logic [DW-1:0] div_val = '0;
   logic          src_ext = 1'b0;
   logic          ext_clk = 1'b0;
   logic          sdi = 1'b0;
   logic          sclk, sen_n, sdo, sdo_oe, busy, done;
   logic [W-1:0]  rx_word;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   ser_master #(.WORD_W(W), .DIV_W(DW), .SYNC_STAGES(2)) i_ser_master (
      .clk (clk), .rst_n (rst_n), .start (start), .tx_word (tx_word),
      .div_val (div_val), .src_ext (src_ext), .ext_clk (ext_clk), .sdi (sdi),
      .sclk (sclk), .sen_n (sen_n), .sdo (sdo), .sdo_oe (sdo_oe),
      .rx_word (rx_word), .busy (busy), .done (done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(EXT_HALF) ext_clk = ~ext_clk;

   // Edge monitor and slave model, evaluated on the falling system clock.
   int cyc = 0;
   int t_sf, t_sr, t_oer, t_oef, t_done;
   int n_done = 0, n_sf = 0, nr = 0, nf = 0, oe_bad = 0;
   int rise_t [W];
   int fall_t [W];
   logic [W-1:0] cap_tx = '0;
   logic [W-1:0] slave_word = '0;
   logic p_sen = 1'b1, p_sclk = 1'b0, p_oe = 1'b0, p_sdo = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (p_sen && !sen_n) begin
            t_sf = cyc; nr = 0; nf = 0; n_sf++; oe_bad = 0; cap_tx = '0;
            sdi = slave_word[W-1];
         end
         if (!p_sclk && sclk) begin
            if (nr < W) rise_t[nr] = cyc;
            cap_tx = {cap_tx[W-2:0], p_sdo};
            if (!p_oe) oe_bad++;
            nr++;
            if (nr < W) sdi = slave_word[W-1-nr];
         end
         if (p_sclk && !sclk) begin
            if (nf < W) fall_t[nf] = cyc;
            nf++;
         end
         if (!p_oe && sdo_oe) t_oer = cyc;
         if (p_oe && !sdo_oe) t_oef = cyc;
         if (!p_sen && sen_n) t_sr = cyc;
         if (done) begin n_done++; t_done = cyc; end
      end
      p_sen = sen_n; p_sclk = sclk; p_oe = sdo_oe; p_sdo = sdo;
   end

   function automatic int exp_hi(input int d);
      int e;
      e = (d == 0) ? 1 : d;
      return (e % 2 == 0) ? e / 2 + 1 : (e + 1) / 2;
   endfunction

   function automatic int exp_lo(input int d);
      int e;
      e = (d == 0) ? 1 : d;
      return (e % 2 == 0) ? e / 2 : (e + 1) / 2;
   endfunction

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] sw,
                           input int dv, input bit ext, input bit poke);
      int tc, h, l, nd0, nsf0;
      tc = ext ? TC_EXT : TC_INT;
      h  = exp_hi(dv);
      l  = exp_lo(dv);
      @(negedge clk);
      tx_word = tx; div_val = DW'(dv); src_ext = ext; slave_word = sw;
      nd0 = n_done; nsf0 = n_sf;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy after start", busy, 1);
      if (poke) begin
         repeat (12) @(negedge clk);
         tx_word = ~tx; div_val = DW'(dv + 3); start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b1, "R9 busy kept on start while busy", busy, 1);
      end
      while (n_done == nd0) @(posedge clk);
      @(negedge clk);
      chk(rise_t[0] - t_sf == (h + l) * tc, "R4 enable lead", rise_t[0] - t_sf, (h + l) * tc);
      chk(rise_t[1] - rise_t[0] == (h + l) * tc, "R3 bit period in system clocks",
          rise_t[1] - rise_t[0], (h + l) * tc);
      chk(t_oer - t_sf == l * tc, "R5 first bit delay", t_oer - t_sf, l * tc);
      chk(cap_tx == tx, "R5 transmitted word", int'(cap_tx), int'(tx));
      chk(oe_bad == 0, "R5 drive enabled at each rise", oe_bad, 0);
      for (int k = 0; k < W - 1; k++) begin
         chk(fall_t[k] - rise_t[k] == h * tc, "R2 high phase", fall_t[k] - rise_t[k], h * tc);
         chk(rise_t[k+1] - fall_t[k] == l * tc, "R2 low phase", rise_t[k+1] - fall_t[k], l * tc);
      end
      chk(t_sr - rise_t[W-1] == h * tc, "R7 enable tail", t_sr - rise_t[W-1], h * tc);
      chk(fall_t[W-1] == t_sr, "R7 clock falls at release", fall_t[W-1], t_sr);
      chk(t_oef == rise_t[W-1], "R7 drive off at last rise", t_oef, rise_t[W-1]);
      chk(nr == W, "R10 rising edge count", nr, W);
      chk(rx_word == sw, "R6 received word", int'(rx_word), int'(sw));
      chk(t_done == t_sr, "R8 done with release", t_done, t_sr);
      chk(n_done - nd0 == 1, "R8 single done pulse", n_done - nd0, 1);
      chk(busy == 1'b0, "R8 busy cleared", busy, 0);
      if (poke) begin
         repeat (40) @(negedge clk);
         chk(n_sf - nsf0 == 1, "R9 no extra transfer", n_sf - nsf0, 1);
         chk(sen_n == 1'b1, "R9 enable stays released", sen_n, 1);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0123));
      repeat (4) @(negedge clk);
      chk(sclk == 1'b0 && sen_n == 1'b1, "R1 lines idle in reset", {sclk, sen_n}, 1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
      chk(sen_n == 1'b1, "R1 enable idle", sen_n, 1);
      chk(sdo_oe == 1'b0, "R1 drive idle", sdo_oe, 0);
      chk(busy == 1'b0 && done == 1'b0, "R1 status idle", {busy, done}, 0);

      run_xfer(8'hA5, 8'h3C, 0, 1'b0, 1'b0);   // divide 0 runs as 1
      run_xfer(8'h81, 8'h7E, 1, 1'b0, 1'b0);
      run_xfer(8'hFF, 8'h00, 2, 1'b0, 1'b0);   // even: high one tick longer
      run_xfer(8'h00, 8'hFF, 7, 1'b1, 1'b0);   // external source, odd
      run_xfer(8'h5A, 8'hC3, 4, 1'b1, 1'b0);   // external source, even
      run_xfer(8'h96, 8'h69, 3, 1'b0, 1'b1);   // start while busy ignored
      run_xfer(8'h1E, 8'hE1, 6, 1'b1, 1'b1);

      for (int i = 0; i < 20; i++) begin
         run_xfer(W'($urandom), W'($urandom), int'($urandom_range(0, 9)),
                  1'($urandom_range(0, 1)), 1'b0);
      end

      repeat (5) @(negedge clk);
      chk(sen_n == 1'b1 && sclk == 1'b0 && sdo_oe == 1'b0, "R1 idle after traffic",
          {sen_n, sclk, sdo_oe}, 3'b100);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule